// File: doc/BRIEF.md
# Snake body segment queue

This block keeps the head and tail of a snake-game character as a fixed array of pre-allocated segment slots. Once per video frame it moves the head by one cell and lets every tail slot follow the slot in front of it. For the pixel that a VGA timing generator presents, it reports whether that pixel lies inside the snake or inside the border wall, and what colour it should have. A crash into the border raises a game-over flag and puts the snake back at its start position.

Each slot stores a coordinate pair and a visible flag. Growing the snake turns on the next unused slot, so no storage is ever created or released while the game runs. The frame update comes from a one-clock tick derived from the pixel coordinates. The pixel outputs are registered, so each result describes the coordinate presented one clock earlier.

Top module: `snake_body_queue`

## Requirements
- R1: A frame tick occurs only when the pixel input is row 481, column 0. The snake state changes only at the second rising edge after that pixel is presented, never for any other pixel pair.
- R2: After reset the head top-left sits at x=311, y=231 with no direction. The snake stays still until a button is taken, no tail slot is visible, and game_over is 0.
- R3: On each frame tick the head moves STEP pixels (10 by default) in the chosen direction. Between ticks the head does not move, and buttons are sampled only at a tick.
- R4: Button bits are btn[0]=down, btn[1]=up, btn[2]=right, btn[3]=left. With several pressed, the first pressed one in the order down, up, right, left is taken.
- R5: A request for the exact reverse of the current direction is ignored, and the snake keeps its direction.
- R6: A request is ignored when it would take the head within one cell of the playfield edge on that side. The next pressed button in priority order is then considered. The limits are: down needs top+SIZE-1 < MAX_Y-1-SIZE; up needs top > SIZE; right needs left+SIZE-1 < MAX_X-1-SIZE; left needs left > SIZE.
- R7: On a frame tick, slot 0 takes the old head position and each later slot takes the old position of the slot ahead of it.
- R8: A grow pulse between ticks, or in the tick cycle, makes the first invisible slot visible at the next tick. When all SLOTS slots are visible, a grow request is ignored. Invisible slots are never drawn.
- R9: On a tick where the head square overlaps any wall band, game_over becomes 1 until the next tick. The head returns to (311,231) with no direction, and all slots become invisible.
- R10: snake_pix is 1 one clock after a pixel with left<=x<=left+SIZE-1 and top<=y<=top+SIZE-1 for the head or for any visible slot.
- R11: The wall bands are WALL_T pixels wide along all four playfield edges. rgb is SNAKE_RGB (3'b010) when snake_pix is 1, else 3'b001 when wall_pix is 1, else 3'b000. The snake colour wins over the wall colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 4 | Direction buttons: down, up, right, left in bits 0 to 3 |
| grow | input | 1 | Request to lengthen the tail by one slot |
| px | input | CW | Current pixel column |
| py | input | CW | Current pixel row |
| snake_pix | output | 1 | Registered: pixel lies in the head or a visible slot |
| wall_pix | output | 1 | Registered: pixel lies in a wall band |
| rgb | output | 3 | Registered pixel colour |
| game_over | output | 1 | Set by a wall crash until the next frame tick |

## Verification
The assertions check on every cycle that the frame tick follows only the trigger pixel, and that the head and the visible-slot flags hold still between ticks. They also check that game over always coincides with the head at its start position, that the direction is idle just after reset, and that the colour output matches the two pixel flags. The ordering of the buttons, the rejection of reversals and of edge-limited turns, the way the tail follows the head, growth up to and beyond capacity, and the exact tick on which a crash occurs can only be shown by the bench's scenarios. The bench observes all of these through pixel probes.

// File: rtl/snake_pkg.sv
package snake_pkg;
  typedef enum logic [2:0] {
    DIR_IDLE  = 3'd0,
    DIR_DOWN  = 3'd1,
    DIR_UP    = 3'd2,
    DIR_RIGHT = 3'd3,
    DIR_LEFT  = 3'd4
  } dir_e;
endpackage

// File: rtl/snake_tick_gen.sv
module snake_tick_gen #(
  parameter int CW  = 10,
  parameter int ROW = 481,
  parameter int COL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  output logic          tick
);
  localparam logic [CW-1:0] ROW_C = CW'(ROW);
  localparam logic [CW-1:0] COL_C = CW'(COL);

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= (py == ROW_C) && (px == COL_C);
  end
endmodule

// File: rtl/snake_head_ctrl.sv
module snake_head_ctrl
  import snake_pkg::*;
#(
  parameter int CW      = 10,
  parameter int SIZE    = 10,
  parameter int STEP    = 10,
  parameter int MAX_X   = 640,
  parameter int MAX_Y   = 480,
  parameter int WALL_T  = 8,
  parameter int START_X = 311,
  parameter int START_Y = 231
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [3:0]    btn,
  output logic [CW-1:0] head_x,
  output logic [CW-1:0] head_y,
  output dir_e          dir,
  output logic          game_over,
  output logic          crash,
  output logic          advance
);
  localparam logic [CW-1:0] STEP_C = CW'(STEP);
  localparam logic [CW-1:0] SX_C   = CW'(START_X);
  localparam logic [CW-1:0] SY_C   = CW'(START_Y);

  logic          overlap;
  dir_e          req, dir_n;
  logic          rev;
  logic [CW-1:0] nx, ny;

  always_comb begin
    int x0, y0;
    logic can_dn, can_up, can_rt, can_lf;
    x0 = int'(head_x);
    y0 = int'(head_y);
    overlap = (x0 <= WALL_T - 1) || (x0 + SIZE - 1 >= MAX_X - WALL_T) ||
              (y0 <= WALL_T - 1) || (y0 + SIZE - 1 >= MAX_Y - WALL_T);
    can_dn = (y0 + SIZE - 1) < (MAX_Y - 1 - SIZE);
    can_up = y0 > SIZE;
    can_rt = (x0 + SIZE - 1) < (MAX_X - 1 - SIZE);
    can_lf = x0 > SIZE;
    if      (btn[0] && can_dn) req = DIR_DOWN;
    else if (btn[1] && can_up) req = DIR_UP;
    else if (btn[2] && can_rt) req = DIR_RIGHT;
    else if (btn[3] && can_lf) req = DIR_LEFT;
    else                       req = DIR_IDLE;
    rev = (req == DIR_DOWN  && dir == DIR_UP)    ||
          (req == DIR_UP    && dir == DIR_DOWN)  ||
          (req == DIR_RIGHT && dir == DIR_LEFT)  ||
          (req == DIR_LEFT  && dir == DIR_RIGHT);
    dir_n = (req != DIR_IDLE && !rev) ? req : dir;
    nx = head_x;
    ny = head_y;
    case (dir_n)
      DIR_DOWN:  ny = head_y + STEP_C;
      DIR_UP:    ny = head_y - STEP_C;
      DIR_RIGHT: nx = head_x + STEP_C;
      DIR_LEFT:  nx = head_x - STEP_C;
      default: ;
    endcase
  end

  assign crash   = tick && overlap;
  assign advance = tick && !overlap;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_x    <= SX_C;
      head_y    <= SY_C;
      dir       <= DIR_IDLE;
      game_over <= 1'b0;
    end else if (crash) begin
      head_x    <= SX_C;
      head_y    <= SY_C;
      dir       <= DIR_IDLE;
      game_over <= 1'b1;
    end else if (advance) begin
      head_x    <= nx;
      head_y    <= ny;
      dir       <= dir_n;
      game_over <= 1'b0;
    end
  end
endmodule

// File: rtl/snake_tail_array.sv
module snake_tail_array #(
  parameter int CW      = 10,
  parameter int SLOTS   = 16,
  parameter int START_X = 311,
  parameter int START_Y = 231
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      advance,
  input  logic                      crash,
  input  logic                      grow,
  input  logic [CW-1:0]             head_x,
  input  logic [CW-1:0]             head_y,
  output logic [SLOTS-1:0][CW-1:0]  seg_x,
  output logic [SLOTS-1:0][CW-1:0]  seg_y,
  output logic [SLOTS-1:0]          active
);
  localparam logic [CW-1:0] SX_C = CW'(START_X);
  localparam logic [CW-1:0] SY_C = CW'(START_Y);

  logic pending;
  logic want;
  assign want = pending || grow;

  always_ff @(posedge clk) begin
    if (rst || crash)  pending <= 1'b0;
    else if (advance)  pending <= 1'b0;
    else if (grow)     pending <= 1'b1;
  end

  // visible flags fill from slot 0 upward as a thermometer code
  always_ff @(posedge clk) begin
    if (rst || crash)
      active <= '0;
    else if (advance && want && !active[SLOTS-1])
      active <= {active[SLOTS-2:0], 1'b1};
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [CW-1:0] src_x, src_y;
      if (g == 0) begin : g_first
        assign src_x = head_x;
        assign src_y = head_y;
      end else begin : g_rest
        assign src_x = seg_x[g-1];
        assign src_y = seg_y[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst || crash) begin
          seg_x[g] <= SX_C;
          seg_y[g] <= SY_C;
        end else if (advance) begin
          seg_x[g] <= src_x;
          seg_y[g] <= src_y;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/snake_pixel_hit.sv
module snake_pixel_hit #(
  parameter int          CW        = 10,
  parameter int          SIZE      = 10,
  parameter int          SLOTS     = 16,
  parameter int          MAX_X     = 640,
  parameter int          MAX_Y     = 480,
  parameter int          WALL_T    = 8,
  parameter logic [2:0]  SNAKE_RGB = 3'b010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            px,
  input  logic [CW-1:0]            py,
  input  logic [CW-1:0]            head_x,
  input  logic [CW-1:0]            head_y,
  input  logic [SLOTS-1:0][CW-1:0] seg_x,
  input  logic [SLOTS-1:0][CW-1:0] seg_y,
  input  logic [SLOTS-1:0]         active,
  output logic                     snake_pix,
  output logic                     wall_pix,
  output logic [2:0]               rgb
);
  localparam int EW = CW + 1;
  localparam logic [2:0] WALL_RGB = 3'b001;

  function automatic logic in_square(input logic [CW-1:0] l, input logic [CW-1:0] t,
                                     input logic [CW-1:0] x, input logic [CW-1:0] y);
    logic [EW-1:0] r, b;
    r = {1'b0, l} + EW'(SIZE - 1);
    b = {1'b0, t} + EW'(SIZE - 1);
    return ({1'b0, x} >= {1'b0, l}) && ({1'b0, x} <= r) &&
           ({1'b0, y} >= {1'b0, t}) && ({1'b0, y} <= b);
  endfunction

  logic [SLOTS-1:0] seg_hit;
  logic             head_hit, body_hit, wall_hit;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
      assign seg_hit[g] = active[g] && in_square(seg_x[g], seg_y[g], px, py);
    end
  endgenerate

  assign head_hit = in_square(head_x, head_y, px, py);
  assign body_hit = head_hit || (|seg_hit);
  assign wall_hit = (int'(px) < WALL_T) || (int'(px) >= MAX_X - WALL_T) ||
                    (int'(py) < WALL_T) || (int'(py) >= MAX_Y - WALL_T);

  always_ff @(posedge clk) begin
    if (rst) begin
      snake_pix <= 1'b0;
      wall_pix  <= 1'b0;
      rgb       <= 3'b000;
    end else begin
      snake_pix <= body_hit;
      wall_pix  <= wall_hit;
      rgb       <= body_hit ? SNAKE_RGB : (wall_hit ? WALL_RGB : 3'b000);
    end
  end
endmodule

// File: rtl/snake_body_queue.sv
module snake_body_queue
  import snake_pkg::*;
#(
  parameter int         CW        = 10,
  parameter int         SLOTS     = 16,
  parameter int         SIZE      = 10,
  parameter int         STEP      = 10,
  parameter int         MAX_X     = 640,
  parameter int         MAX_Y     = 480,
  parameter int         WALL_T    = 8,
  parameter int         START_X   = 311,
  parameter int         START_Y   = 231,
  parameter int         TICK_ROW  = 481,
  parameter int         TICK_COL  = 0,
  parameter logic [2:0] SNAKE_RGB = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    btn,
  input  logic          grow,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  output logic          snake_pix,
  output logic          wall_pix,
  output logic [2:0]    rgb,
  output logic          game_over
);
  logic                     tick, crash, advance;
  logic [CW-1:0]            head_x, head_y;
  dir_e                     dir;
  logic [SLOTS-1:0][CW-1:0] seg_x, seg_y;
  logic [SLOTS-1:0]         active;

  snake_tick_gen #(.CW(CW), .ROW(TICK_ROW), .COL(TICK_COL)) u_tick (
    .clk(clk), .rst(rst), .px(px), .py(py), .tick(tick)
  );

  snake_head_ctrl #(
    .CW(CW), .SIZE(SIZE), .STEP(STEP), .MAX_X(MAX_X), .MAX_Y(MAX_Y),
    .WALL_T(WALL_T), .START_X(START_X), .START_Y(START_Y)
  ) u_head (
    .clk(clk), .rst(rst), .tick(tick), .btn(btn),
    .head_x(head_x), .head_y(head_y), .dir(dir),
    .game_over(game_over), .crash(crash), .advance(advance)
  );

  snake_tail_array #(
    .CW(CW), .SLOTS(SLOTS), .START_X(START_X), .START_Y(START_Y)
  ) u_tail (
    .clk(clk), .rst(rst), .advance(advance), .crash(crash), .grow(grow),
    .head_x(head_x), .head_y(head_y),
    .seg_x(seg_x), .seg_y(seg_y), .active(active)
  );

  snake_pixel_hit #(
    .CW(CW), .SIZE(SIZE), .SLOTS(SLOTS), .MAX_X(MAX_X), .MAX_Y(MAX_Y),
    .WALL_T(WALL_T), .SNAKE_RGB(SNAKE_RGB)
  ) u_hit (
    .clk(clk), .rst(rst), .px(px), .py(py),
    .head_x(head_x), .head_y(head_y),
    .seg_x(seg_x), .seg_y(seg_y), .active(active),
    .snake_pix(snake_pix), .wall_pix(wall_pix), .rgb(rgb)
  );
endmodule

// File: rtl/snake_body_queue_chk.sv
module snake_body_queue_chk
  import snake_pkg::*;
#(
  parameter int         CW        = 10,
  parameter int         SLOTS     = 16,
  parameter int         START_X   = 311,
  parameter int         START_Y   = 231,
  parameter int         TICK_ROW  = 481,
  parameter int         TICK_COL  = 0,
  parameter logic [2:0] SNAKE_RGB = 3'b010
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    px,
  input logic [CW-1:0]    py,
  input logic             tick,
  input logic [CW-1:0]    head_x,
  input logic [CW-1:0]    head_y,
  input dir_e             dir,
  input logic [SLOTS-1:0] active,
  input logic             game_over,
  input logic             snake_pix,
  input logic             wall_pix,
  input logic [2:0]       rgb
);
  // R1
  tick_source_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(py) == CW'(TICK_ROW) && $past(px) == CW'(TICK_COL)));

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(head_x) && $stable(head_y)));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(active));

  // R9
  crash_home_chk: assert property (@(posedge clk) disable iff (rst)
    game_over |-> (head_x == CW'(START_X) && head_y == CW'(START_Y) && dir == DIR_IDLE));

  // R2
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dir == DIR_IDLE && active == '0 && !game_over));

  // R11
  snake_colour_chk: assert property (@(posedge clk) disable iff (rst)
    snake_pix |-> rgb == SNAKE_RGB);

  // R11
  wall_colour_chk: assert property (@(posedge clk) disable iff (rst)
    (wall_pix && !snake_pix) |-> rgb == 3'b001);
endmodule

bind snake_body_queue snake_body_queue_chk #(
  .CW(CW), .SLOTS(SLOTS), .START_X(START_X), .START_Y(START_Y),
  .TICK_ROW(TICK_ROW), .TICK_COL(TICK_COL), .SNAKE_RGB(SNAKE_RGB)
) u_chk (
  .clk(clk), .rst(rst), .px(px), .py(py), .tick(tick),
  .head_x(head_x), .head_y(head_y), .dir(dir), .active(active),
  .game_over(game_over), .snake_pix(snake_pix), .wall_pix(wall_pix), .rgb(rgb)
);

// File: tb/snake_body_queue_test.sv
module snake_body_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    btn = 4'b0000;
  logic          grow = 1'b0;
  logic [CW-1:0] px = '0;
  logic [CW-1:0] py = '0;
  logic          snake_pix, wall_pix, game_over;
  logic [2:0]    rgb;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snake_body_queue #(.CW(CW), .SLOTS(3)) uut (
    .clk(clk), .rst(rst), .btn(btn), .grow(grow), .px(px), .py(py),
    .snake_pix(snake_pix), .wall_pix(wall_pix), .rgb(rgb), .game_over(game_over)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic probe(input int x, input int y, output int s, output int w, output int c);
    @(negedge clk); px = CW'(x); py = CW'(y);
    @(negedge clk); s = int'(snake_pix); w = int'(wall_pix); c = int'(rgb);
  endtask

  task automatic probe_snake(input string tag, input int x, input int y, input int exp);
    int s, w, c;
    probe(x, y, s, w, c);
    check(tag, s, exp);
  endtask

  task automatic frame_tick(input logic [3:0] b);
    @(negedge clk); btn = b; px = '0; py = CW'(481);
    @(negedge clk); px = CW'(1); py = '0;
    @(negedge clk); btn = 4'b0000;
  endtask

  task automatic pulse_grow;
    @(negedge clk); grow = 1'b1;
    @(negedge clk); grow = 1'b0;
  endtask

  task automatic test_reset;
    int s, w, c;
    check("R2 game_over after reset", int'(game_over), 0);
    probe(311, 231, s, w, c);
    check("R2 head at start", s, 1);
    check("R11 snake colour", c, 2);
    probe_snake("R10 right edge outside", 321, 231, 0);
    probe_snake("R10 left edge outside", 310, 231, 0);
    probe_snake("R10 far corner inside", 320, 240, 1);
    frame_tick(4'b0000);
    probe_snake("R2 stationary without button", 311, 231, 1);
  endtask

  task automatic test_latency;
    @(negedge clk); px = CW'(311); py = CW'(231);
    @(negedge clk);
    px = CW'(100); py = CW'(100);
    check("R10 hit one clock after pixel", int'(snake_pix), 1);
    @(negedge clk);
    check("R10 miss one clock after pixel", int'(snake_pix), 0);
  endtask

  task automatic test_tick_only;
    @(negedge clk); btn = 4'b0100; px = CW'(1); py = CW'(481);
    @(negedge clk); px = '0; py = CW'(480);
    @(negedge clk); px = CW'(5); py = CW'(5);
    @(negedge clk); btn = 4'b0000;
    probe_snake("R1 no move without trigger pixel", 311, 231, 1);
    probe_snake("R3 button ignored between ticks", 321, 231, 0);
    frame_tick(4'b0100);
    probe_snake("R3 head stepped right", 321, 231, 1);
    probe_snake("R8 inactive slot not drawn", 311, 231, 0);
  endtask

  task automatic test_follow;
    pulse_grow();
    frame_tick(4'b0000);
    probe_snake("R7 slot0 holds old head", 321, 231, 1);
    probe_snake("R3 head keeps moving", 331, 231, 1);
    probe_snake("R8 only one slot visible", 311, 231, 0);
  endtask

  task automatic test_reverse;
    frame_tick(4'b1000);
    probe_snake("R5 reverse ignored head", 341, 231, 1);
    probe_snake("R7 slot0 follows", 331, 231, 1);
    probe_snake("R7 old slot spot cleared", 321, 231, 0);
  endtask

  task automatic test_priority;
    frame_tick(4'b0101);
    probe_snake("R4 down beats right", 341, 241, 1);
    probe_snake("R4 right not taken", 351, 231, 0);
    probe_snake("R7 slot0 at corner", 341, 231, 1);
  endtask

  task automatic test_capacity;
    pulse_grow(); frame_tick(4'b0000);
    pulse_grow(); frame_tick(4'b0000);
    pulse_grow(); frame_tick(4'b0000);
    probe_snake("R8 head", 341, 271, 1);
    probe_snake("R8 last slot", 341, 241, 1);
    probe_snake("R8 grow ignored when full", 341, 231, 0);
  endtask

  task automatic test_limit;
    for (int i = 0; i < 19; i++) frame_tick(4'b0000);
    probe_snake("R3 head near bottom", 341, 461, 1);
    check("R9 no crash yet", int'(game_over), 0);
    frame_tick(4'b0101);
    probe_snake("R6 down blocked falls to right", 351, 461, 1);
    probe_snake("R6 down not taken", 341, 471, 0);
  endtask

  task automatic test_crash;
    int s, w, c;
    int early = 0;
    for (int k = 0; k < 28; k++) begin
      frame_tick(4'b0000);
      if (game_over) early++;
    end
    check("R9 no game_over before crash tick", early, 0);
    probe(635, 465, s, w, c);
    check("R11 snake in wall band", s, 1);
    check("R11 wall flag in band", w, 1);
    check("R11 snake colour wins", c, 2);
    frame_tick(4'b0000);
    check("R9 game_over on crash tick", int'(game_over), 1);
    probe_snake("R9 head back at start", 311, 231, 1);
    probe_snake("R9 tail cleared", 621, 461, 0);
    frame_tick(4'b0000);
    check("R9 game_over clears next tick", int'(game_over), 0);
    probe_snake("R9 idle after crash", 311, 231, 1);
  endtask

  task automatic test_colours;
    int s, w, c;
    probe(3, 100, s, w, c);
    check("R11 wall flag", w, 1);
    check("R11 wall colour", c, 1);
    probe(100, 100, s, w, c);
    check("R11 background colour", c, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_latency();
    test_tick_only();
    test_follow();
    test_reverse();
    test_priority();
    test_capacity();
    test_limit();
    test_crash();
    test_colours();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule